// File: doc/BRIEF.md
# Interrupt Aggregator with Destination Mapping

This block collects a large set of level-high interrupt sources from inside a chip and latches each one into a sticky status bit. Software arms each source with an enable bit. It then steers the source to any subset of the destination interrupt lines through per-destination routing masks. A destination line stays high while at least one source routed to it is latched and enabled. For each destination, software reads an identification word that lists exactly those sources.

Software reaches the state through a simple word-addressed register bus. It uses a write strobe, a read strobe, an address and 32-bit data. Read data is registered and appears in the cycle after the read strobe. The sources are split into 32-bit banks. Enable bits are never written directly: each bank has a set port and a clear port, so two agents can change different enables without a read-modify-write. The asynchronous active-low reset is released synchronously inside the block.

Top module: `irq_route_hub`

## Requirements
- R1: After reset every sticky, enable and routing bit is zero, every register reads zero and all destination lines are low.
- R2: A source that is high at a clock edge sets its sticky bit at that edge, whether or not it is enabled. The bit stays set until acknowledged. Sticky words are read at 0x30, 0x34 and 0x38 for banks 0, 1 and 2, and bank b bit i is source 32b+i.
- R3: Writing 1 to a sticky bit clears it, and writing 0 leaves it alone. If the source is high in the cycle of that write, the bit stays set.
- R4: Writing 1 to an enable-set word (0x60, 0x64, 0x68) sets the matching enable bit. A 0 in that word leaves the bit unchanged.
- R5: Writing 1 to an enable-clear word (0x54, 0x58, 0x5C) clears the matching enable bit. A 0 in that word leaves the bit unchanged.
- R6: The enable bits read back at 0x48, 0x4C and 0x50. The set and clear words read as zero.
- R7: The routing mask for destination n (0 to 8) is read/write at 0x78+4n, 0x9C+4n and 0xC0+4n for banks 0, 1 and 2.
- R8: The identification word for destination n, at 0xE4+4n, 0x108+4n and 0x12C+4n, reads sticky AND enable AND routing mask for that destination. Writes to it have no effect.
- R9: Destination line n is high exactly when any identification bit of destination n, in any bank, is set. It is low again once those bits are acknowledged.
- R10: Bits 22 to 31 of bank 2 map to no source. They read zero in every register, and writes to them are ignored.
- R11: Addresses that decode to no register read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 86 | Level-high interrupt sources |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| dst_irq | output | 9 | Destination interrupt lines |

## Verification
The destination lines come straight from the sticky, enable and routing registers. A corrupted bit in any of them therefore shows on dst_irq in the cycle after the edge that stored it. Read-back shows it one cycle after the read strobe. A sticky bit that drops without an acknowledge, or that fails to latch, shows first on the identification word and on the line of every destination it is routed to. A fault in the set/clear logic shows as an enable word differing in bits that the write did not name. The bench compares every stored word against values worked out from the requirements. It also watches the lines while acknowledges race live sources.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned BANK_W = 32;

  // word offsets of the register groups
  localparam int unsigned STK_BASE = 32'h030;
  localparam int unsigned ENA_BASE = 32'h048;
  localparam int unsigned CLR_BASE = 32'h054;
  localparam int unsigned SET_BASE = 32'h060;
  localparam int unsigned MAP_BASE = 32'h078;
  localparam int unsigned IDT_BASE = 32'h0E4;

  function automatic logic [BANK_W-1:0] bank_mask(int unsigned nsrc, int unsigned b);
    logic [BANK_W-1:0] m;
    for (int unsigned i = 0; i < BANK_W; i++) begin
      m[i] = ((b * BANK_W + i) < nsrc);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_hub_rstsync.sv
module irq_hub_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int unsigned NB = 3,
  parameter int unsigned ND = 9,
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0]         addr,
  output logic [NB-1:0]         hit_stk,
  output logic [NB-1:0]         hit_ena,
  output logic [NB-1:0]         hit_clr,
  output logic [NB-1:0]         hit_set,
  output logic [NB-1:0][ND-1:0] hit_map,
  output logic [NB-1:0][ND-1:0] hit_idt
);
  localparam int unsigned GRP_STRIDE = ND * 4;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [AW-1:0] A_STK = AW'(STK_BASE + 4 * b);
    localparam logic [AW-1:0] A_ENA = AW'(ENA_BASE + 4 * b);
    localparam logic [AW-1:0] A_CLR = AW'(CLR_BASE + 4 * b);
    localparam logic [AW-1:0] A_SET = AW'(SET_BASE + 4 * b);
    assign hit_stk[b] = (addr == A_STK);
    assign hit_ena[b] = (addr == A_ENA);
    assign hit_clr[b] = (addr == A_CLR);
    assign hit_set[b] = (addr == A_SET);
    for (genvar d = 0; d < ND; d++) begin : g_dst
      localparam logic [AW-1:0] A_MAP = AW'(MAP_BASE + GRP_STRIDE * b + 4 * d);
      localparam logic [AW-1:0] A_IDT = AW'(IDT_BASE + GRP_STRIDE * b + 4 * d);
      assign hit_map[b][d] = (addr == A_MAP);
      assign hit_idt[b][d] = (addr == A_IDT);
    end
  end
endmodule

// File: rtl/irq_hub_bank.sv
module irq_hub_bank
  import irq_hub_pkg::*;
#(
  parameter int unsigned       ND    = 9,
  parameter logic [BANK_W-1:0] VMASK = '1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [BANK_W-1:0]          src,
  input  logic [BANK_W-1:0]          wdata,
  input  logic                       ack_we,
  input  logic                       set_we,
  input  logic                       clr_we,
  input  logic [ND-1:0]              map_we,
  output logic [BANK_W-1:0]          sticky_o,
  output logic [BANK_W-1:0]          ena_o,
  output logic [ND-1:0][BANK_W-1:0]  map_o,
  output logic [ND-1:0][BANK_W-1:0]  idt_o
);
  logic [BANK_W-1:0]         sticky_q, sticky_d;
  logic [BANK_W-1:0]         ena_q, ena_d;
  logic [ND-1:0][BANK_W-1:0] map_q, map_d;
  logic                      sticky_en, ena_en;
  logic [BANK_W-1:0]         src_v, wdat_v;

  assign src_v  = src & VMASK;
  assign wdat_v = wdata & VMASK;

  // next state: a live source overrides an acknowledge in the same cycle
  always_comb begin
    sticky_en = ack_we | (|src_v);
    sticky_d  = (sticky_q & ~(ack_we ? wdat_v : '0)) | src_v;
    ena_en    = set_we | clr_we;
    ena_d     = ena_q;
    if (set_we) ena_d = ena_q | wdat_v;
    if (clr_we) ena_d = ena_q & ~wdat_v;
    for (int d = 0; d < int'(ND); d++) begin
      map_d[d] = map_we[d] ? wdat_v : map_q[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      ena_q    <= '0;
    end else begin
      if (sticky_en) sticky_q <= sticky_d;
      if (ena_en)    ena_q    <= ena_d;
    end
  end

  for (genvar d = 0; d < ND; d++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         map_q[d] <= '0;
      else if (map_we[d]) map_q[d] <= map_d[d];
    end
    assign idt_o[d] = sticky_q & ena_q & map_q[d];
  end

  assign sticky_o = sticky_q;
  assign ena_o    = ena_q;
  assign map_o    = map_q;
endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 86,
  parameter int unsigned NUM_DST = 9,
  parameter int unsigned AW      = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [AW-1:0]       bus_addr,
  input  logic [BANK_W-1:0]   bus_wdata,
  output logic [BANK_W-1:0]   bus_rdata,
  output logic [NUM_DST-1:0]  dst_irq
);
  localparam int unsigned NB    = (NUM_SRC + BANK_W - 1) / BANK_W;
  localparam int unsigned PAD_W = NB * BANK_W;

  logic                           rst_sync_n;
  logic [PAD_W-1:0]               src_pad;
  logic [NB-1:0]                  hit_stk, hit_ena, hit_clr, hit_set;
  logic [NB-1:0][NUM_DST-1:0]     hit_map, hit_idt;
  logic [NB-1:0][BANK_W-1:0]      stk_b, ena_b;
  logic [NB-1:0][NUM_DST-1:0][BANK_W-1:0] map_b, idt_b;
  logic [PAD_W-1:0]               sticky_all, ena_all;
  logic [BANK_W-1:0]              rd_mux, rdata_q;
  logic [NUM_DST-1:0]             dst_d;

  irq_hub_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign src_pad = PAD_W'(src_i);

  irq_hub_decode #(.NB(NB), .ND(NUM_DST), .AW(AW)) u_dec (
    .addr    (bus_addr),
    .hit_stk (hit_stk),
    .hit_ena (hit_ena),
    .hit_clr (hit_clr),
    .hit_set (hit_set),
    .hit_map (hit_map),
    .hit_idt (hit_idt)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    irq_hub_bank #(.ND(NUM_DST), .VMASK(bank_mask(NUM_SRC, b))) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .src      (src_pad[b*BANK_W +: BANK_W]),
      .wdata    (bus_wdata),
      .ack_we   (bus_wr & hit_stk[b]),
      .set_we   (bus_wr & hit_set[b]),
      .clr_we   (bus_wr & hit_clr[b]),
      .map_we   ({NUM_DST{bus_wr}} & hit_map[b]),
      .sticky_o (stk_b[b]),
      .ena_o    (ena_b[b]),
      .map_o    (map_b[b]),
      .idt_o    (idt_b[b])
    );
    assign sticky_all[b*BANK_W +: BANK_W] = stk_b[b];
    assign ena_all[b*BANK_W +: BANK_W]    = ena_b[b];
  end

  // one-hot decode, so an OR of the selected words forms the mux
  always_comb begin
    rd_mux = '0;
    dst_d  = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (hit_stk[b]) rd_mux = rd_mux | stk_b[b];
      if (hit_ena[b]) rd_mux = rd_mux | ena_b[b];
      for (int d = 0; d < int'(NUM_DST); d++) begin
        if (hit_map[b][d]) rd_mux = rd_mux | map_b[b][d];
        if (hit_idt[b][d]) rd_mux = rd_mux | idt_b[b][d];
        dst_d[d] = dst_d[d] | (|idt_b[b][d]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_rd)  rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign dst_irq   = dst_d;
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 86,
  parameter int unsigned NUM_DST = 9,
  parameter int unsigned AW      = 12,
  parameter int unsigned PAD_W   = 96
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_wr,
  input logic [AW-1:0]      bus_addr,
  input logic [BANK_W-1:0]  bus_wdata,
  input logic [PAD_W-1:0]   stk_all,
  input logic [PAD_W-1:0]   ena_all,
  input logic [NUM_DST-1:0] dst_irq
);
  logic [PAD_W-1:0] src_w;
  assign src_w = PAD_W'(src_i);

  // R2/R3: a live source is latched at the next edge, even against an ack
  a_r2_sticky_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (src_w != '0) |=> ((stk_all & $past(src_w)) == $past(src_w)));

  // R2: sticky bits only fall in the cycle after a bus write
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (($past(stk_all) & ~stk_all) == '0));

  // R4: bank 0 set word raises every named enable
  a_r4_set_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(SET_BASE)) |=>
      ((ena_all[BANK_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R5: bank 0 clear word drops every named enable
  a_r5_clr_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(CLR_BASE)) |=>
      ((ena_all[BANK_W-1:0] & $past(bus_wdata)) == '0));

  // R9: a destination line implies a latched, enabled source
  a_r9_dst_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_irq != '0) |-> ((stk_all & ena_all) != '0));

  // R10: padding bits never hold an enable or a sticky
  a_r10_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((ena_all >> NUM_SRC) == '0) && ((stk_all >> NUM_SRC) == '0));
endmodule

bind irq_route_hub irq_hub_chk #(
  .NUM_SRC (NUM_SRC),
  .NUM_DST (NUM_DST),
  .AW      (AW),
  .PAD_W   (PAD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_i     (src_i),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .stk_all   (sticky_all),
  .ena_all   (ena_all),
  .dst_irq   (dst_irq)
);

// File: tb/irq_route_hub_test.sv
module irq_route_hub_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [85:0] src;
  logic        wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [8:0]  dst;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_route_hub uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .dst_irq   (dst)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_src(input int idx);
    @(negedge clk);
    src[idx] = 1'b1;
    @(negedge clk);
    src[idx] = 1'b0;
  endtask

  task automatic t_reset;
    read_chk("R1 sticky0", 12'h030, 32'h0);
    read_chk("R1 enable2", 12'h050, 32'h0);
    read_chk("R1 map b1 d8", 12'h0BC, 32'h0);
    check("R1 dst lines", 32'(dst), 32'h0);
  endtask

  task automatic t_sticky;
    pulse_src(5);
    read_chk("R2 sticky latched unenabled", 12'h030, 32'h20);
    check("R9 no line without enable", 32'(dst), 32'h0);
    bus_write(12'h030, 32'h0);
    read_chk("R3 ack with zero keeps", 12'h030, 32'h20);
    bus_write(12'h030, 32'h20);
    read_chk("R3 ack clears", 12'h030, 32'h0);
  endtask

  task automatic t_relatch;
    @(negedge clk);
    src[40] = 1'b1;
    bus_write(12'h034, 32'h100);
    read_chk("R3 live source relatches", 12'h034, 32'h100);
    @(negedge clk);
    src[40] = 1'b0;
    bus_write(12'h034, 32'h100);
    read_chk("R3 ack after release", 12'h034, 32'h0);
  endtask

  task automatic t_enable;
    bus_write(12'h060, 32'hF0);
    bus_write(12'h060, 32'h0F);
    read_chk("R4 set accumulates", 12'h048, 32'hFF);
    bus_write(12'h054, 32'h30);
    read_chk("R5 clear named bits", 12'h048, 32'hCF);
    bus_write(12'h054, 32'h0);
    read_chk("R5 clear zero no effect", 12'h048, 32'hCF);
    read_chk("R6 set word reads zero", 12'h060, 32'h0);
    read_chk("R6 clear word reads zero", 12'h054, 32'h0);
  endtask

  task automatic t_route;
    bus_write(12'h068, 32'h40);
    bus_write(12'h0D0, 32'h40);
    read_chk("R7 map b2 d4 readback", 12'h0D0, 32'h40);
    pulse_src(70);
    check("R9 dst4 asserted", 32'(dst), 32'h010);
    read_chk("R8 ident b2 d4", 12'h13C, 32'h40);
    read_chk("R8 ident b2 d3 empty", 12'h138, 32'h0);
    bus_write(12'h13C, 32'h0);
    read_chk("R8 ident write ignored", 12'h13C, 32'h40);
    bus_write(12'h0E0, 32'h40);
    check("R9 fan-out to dst8", 32'(dst), 32'h110);
    bus_write(12'h078, 32'h1);
    pulse_src(0);
    check("R9 cross-bank dst0", 32'(dst), 32'h111);
    bus_write(12'h038, 32'h40);
    check("R9 ack bank2 drops dst4/8", 32'(dst), 32'h001);
    bus_write(12'h030, 32'h1);
    check("R9 all lines low", 32'(dst), 32'h0);
  endtask

  task automatic t_pad;
    bus_write(12'h068, 32'hFFFF_FFFF);
    read_chk("R10 enable2 upper zero", 12'h050, 32'h003F_FFFF);
    bus_write(12'h0C0, 32'hFFFF_FFFF);
    read_chk("R10 map b2 upper zero", 12'h0C0, 32'h003F_FFFF);
    bus_write(12'h038, 32'hFFFF_FFFF);
    read_chk("R10 sticky2 zero", 12'h038, 32'h0);
  endtask

  task automatic t_unmapped;
    bus_write(12'h044, 32'hFFFF_FFFF);
    read_chk("R11 write ignored", 12'h048, 32'hCF);
    read_chk("R11 hole reads zero", 12'h044, 32'h0);
    read_chk("R11 beyond map", 12'h150, 32'h0);
    read_chk("R11 misaligned", 12'h032, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1-sequence actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_sticky;
    t_relatch;
    t_enable;
    t_route;
    t_pad;
    t_unmapped;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule